// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block holds the interrupt registers of a serial port. It takes the current occupancy counts of the receive and transmit queues and derives a live status word from them: empty, full and at-or-above-threshold flags for each direction. Every clock it folds those flags into a sticky status register. It also folds in single-cycle error pulses from the receive path (overrun, framing, parity, timeout) and from the transmit path (overflow). Software clears sticky bits by writing ones to them.

A mask selects which sticky bits raise the single level-sensitive interrupt line. The mask is never written directly. One register address turns bits on and another turns them off, so two agents can change different bits without a read-modify-write race. The receive and transmit thresholds are held in two small writable registers. The queues, shifters and baud timing sit outside this block and reach it only as counts and pulses.

Top module: `uart_irq_regs`

## Requirements
- R1: Live status (read at address 4) bit 0 is 1 when the receive count is greater than or equal to the receive threshold. Bit 1 is 1 when the receive count is zero. Bit 2 is 1 when the receive count equals RX_DEPTH.
- R2: Live status bit 3 is 1 when the transmit count is zero. Bit 4 is 1 when the transmit count equals TX_DEPTH. Bit 13 is 1 when the transmit count is greater than or equal to the transmit threshold.
- R3: On each clock edge out of reset, live bits 4:0 are ORed into the same positions of the sticky status register (read at address 3). Live bit 13 sets sticky bit 10. The effect is readable right after that edge.
- R4: A write to address 0 ORs the write data into the mask, and a write to address 1 clears the mask bits written as 1. A write to address 2 leaves the mask unchanged. The mask reads at address 2.
- R5: A write to address 3 clears each sticky bit written as 1. If a set source for that bit is active in the same cycle, the bit stays 1.
- R6: The event pulses set sticky bits as follows: receive overrun sets bit 5, framing error sets bit 6, parity error sets bit 7, receive timeout sets bit 8 and transmit overflow sets bit 12. Sticky bits 9, 11 and 13 to 15 always read 0.
- R7: The irq output is 1 exactly when some bit is 1 in both the mask and the sticky status.
- R8: While reset is asserted, the mask and sticky status are 0, irq is 0, and both thresholds (addresses 5 and 6) read 32.
- R9: A write to address 5 or 6 loads the low CNT_W bits of the write data into the receive or transmit threshold. The new value governs live status from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W (16) | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W (16) | Read data, combinational from rd_addr |
| rx_count | input | CNT_W (7) | Receive queue occupancy |
| tx_count | input | CNT_W (7) | Transmit queue occupancy |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_tx_overflow | input | 1 | Transmit overflow pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A bad threshold compare or a bad empty/full flag shows at once on the live status read, because that word is combinational from the counts. It shows on the sticky read and on irq one edge later. A mask or sticky register that takes a wrong value surfaces on irq in the cycle after the offending write or count change, once the matching mask bit is enabled. The sweeps therefore check every count step at the thresholds, at zero and at full against a cycle-exact model of both registers. A lost clear, or a clear that beats a live set, stays visible on the sticky read until the next write, so each W1C is read back before the next stimulus.

// File: rtl/uart_irq_pkg.sv
// Package: shared register selectors and bit positions for the UART
// interrupt unit. Assumes a 3-bit register address space.
package uart_irq_pkg;
    localparam int ADDR_W   = 3;
    localparam int STICKY_W = 13;
    localparam int LIVE_W   = 14;

    typedef enum logic [ADDR_W-1:0] {
        REG_IRQ_SET = 3'd0,
        REG_IRQ_CLR = 3'd1,
        REG_MASK    = 3'd2,
        REG_STICKY  = 3'd3,
        REG_LIVE    = 3'd4,
        REG_RX_TRIG = 3'd5,
        REG_TX_TRIG = 3'd6,
        REG_NONE    = 3'd7
    } reg_sel_e;

    localparam int B_RX_TRIG  = 0;
    localparam int B_RX_EMPTY = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_EMPTY = 3;
    localparam int B_TX_FULL  = 4;
    localparam int B_OVERRUN  = 5;
    localparam int B_FRAME    = 6;
    localparam int B_PARITY   = 7;
    localparam int B_TIMEOUT  = 8;
    localparam int B_TXTRIG_S = 10;
    localparam int B_TX_OVF   = 12;
    localparam int B_TXTRIG_L = 13;
endpackage

// File: rtl/uart_irq_fifo_flags.sv
// Module: occupancy flags for one queue direction. It produces the empty,
// full and at-or-above-threshold flags. Assumes count never exceeds DEPTH.
module uart_irq_fifo_flags #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    output logic             empty,
    output logic             full,
    output logic             trig_hit
);
    localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(DEPTH);

    // Compare the count against zero, capacity and threshold.
    always_comb begin
        empty    = (count == '0);
        full     = (count == FULL_VAL);
        trig_hit = (count >= trig);
    end
endmodule

// File: rtl/uart_irq_mask.sv
// Module: interrupt enable mask, updated only through a set-port and a
// clear-port. Assumes set_en and clr_en are never high together.
module uart_irq_mask #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask_q
);
    // Hold the mask; OR in on set, AND out on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (set_en) mask_q <= mask_q | bits;
        else if (clr_en) mask_q <= mask_q & ~bits;
    end

    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_q & $past(bits)) == $past(bits)));
    p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((mask_q & $past(bits)) == '0));
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_sticky.sv
// Module: sticky interrupt status with write-one-to-clear. A set in the
// same cycle as a clear wins. Assumes vectors are already bit-aligned.
module uart_irq_sticky #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] sticky_q
);
    // Clear the written ones, then OR in this cycle's sources.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_vec) | set_vec;
    end

    p_sticky_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sticky_q & $past(set_vec)) == $past(set_vec)));
    p_sticky_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((sticky_q & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/uart_irq_regs.sv
// Module: top of the UART interrupt unit. It decodes the register port,
// holds the thresholds, builds live status and drives irq from the mask and
// the sticky status. Assumes one write per cycle and counts within depth.
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    parameter int CNT_W    = $clog2(((RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH) + 1),
    parameter int DATA_W   = 16,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_rx_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_timeout,
    input  logic              ev_tx_overflow,
    output logic              irq
);
    localparam logic [CNT_W-1:0] TRIG_INIT = CNT_W'(TRIG_RST);

    reg_sel_e              wsel;
    logic [CNT_W-1:0]      rx_trig_q, tx_trig_q;
    logic                  rx_empty, rx_full, rx_hit;
    logic                  tx_empty, tx_full, tx_hit;
    logic [LIVE_W-1:0]     live;
    logic [STICKY_W-1:0]   set_vec, clr_vec, mask_q, sticky_q;

    assign wsel = reg_sel_e'(wr_addr);

    uart_irq_fifo_flags #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) rx_flags_i (
        .count(rx_count), .trig(rx_trig_q),
        .empty(rx_empty), .full(rx_full), .trig_hit(rx_hit));

    uart_irq_fifo_flags #(.DEPTH(TX_DEPTH), .CNT_W(CNT_W)) tx_flags_i (
        .count(tx_count), .trig(tx_trig_q),
        .empty(tx_empty), .full(tx_full), .trig_hit(tx_hit));

    // Threshold registers, loaded from the low bits of write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig_q <= TRIG_INIT;
            tx_trig_q <= TRIG_INIT;
        end else if (wr_en) begin
            if (wsel == REG_RX_TRIG) rx_trig_q <= wr_data[CNT_W-1:0];
            if (wsel == REG_TX_TRIG) tx_trig_q <= wr_data[CNT_W-1:0];
        end
    end

    // Assemble the live status word from the per-direction flags.
    always_comb begin
        live             = '0;
        live[B_RX_TRIG]  = rx_hit;
        live[B_RX_EMPTY] = rx_empty;
        live[B_RX_FULL]  = rx_full;
        live[B_TX_EMPTY] = tx_empty;
        live[B_TX_FULL]  = tx_full;
        live[B_TXTRIG_L] = tx_hit;
    end

    // Build sticky set sources (live flags plus event pulses) and W1C mask.
    always_comb begin
        set_vec             = '0;
        set_vec[4:0]        = live[4:0];
        set_vec[B_TXTRIG_S] = live[B_TXTRIG_L];
        set_vec[B_OVERRUN]  = ev_rx_overrun;
        set_vec[B_FRAME]    = ev_frame_err;
        set_vec[B_PARITY]   = ev_parity_err;
        set_vec[B_TIMEOUT]  = ev_rx_timeout;
        set_vec[B_TX_OVF]   = ev_tx_overflow;
        clr_vec = (wr_en && wsel == REG_STICKY) ? wr_data[STICKY_W-1:0] : '0;
    end

    uart_irq_mask #(.W(STICKY_W)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(wr_en && wsel == REG_IRQ_SET),
        .clr_en(wr_en && wsel == REG_IRQ_CLR),
        .bits(wr_data[STICKY_W-1:0]),
        .mask_q(mask_q));

    uart_irq_sticky #(.W(STICKY_W)) sticky_i (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .sticky_q(sticky_q));

    // Interrupt request from enabled sticky bits.
    always_comb irq = |(mask_q & sticky_q);

    // Read multiplexer; set/clear ports read back as zero.
    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            REG_MASK:    rd_data = DATA_W'(mask_q);
            REG_STICKY:  rd_data = DATA_W'(sticky_q);
            REG_LIVE:    rd_data = DATA_W'(live);
            REG_RX_TRIG: rd_data = DATA_W'(rx_trig_q);
            REG_TX_TRIG: rd_data = DATA_W'(tx_trig_q);
            default:     rd_data = '0;
        endcase
    end

    p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(live[B_RX_EMPTY] && live[B_RX_FULL]) && !(live[B_TX_EMPTY] && live[B_TX_FULL]));
    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> sticky_q[B_OVERRUN]);
    p_txovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_overflow |=> sticky_q[B_TX_OVF]);
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((mask_q != '0) && (sticky_q != '0)));
    p_txtrig_remap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live[B_TXTRIG_L] |=> sticky_q[B_TXTRIG_S]);
endmodule

// File: tb/uart_irq_regs_tb_top.sv
// Bench: directed scenarios against a cycle model of mask, sticky status
// and thresholds, written from the requirements.
module uart_irq_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic ev_ovr = 0, ev_frm = 0, ev_par = 0, ev_tmo = 0, ev_tovf = 0;
    logic irq;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [12:0]   m_mask = '0, m_sticky = '0;
    logic [CW-1:0] m_rtr = 7'd32, m_ttr = 7'd32;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_count(rx_count), .tx_count(tx_count),
        .ev_rx_overrun(ev_ovr), .ev_frame_err(ev_frm), .ev_parity_err(ev_par),
        .ev_rx_timeout(ev_tmo), .ev_tx_overflow(ev_tovf), .irq(irq));

    function automatic logic [15:0] live_f(logic [CW-1:0] rc, logic [CW-1:0] tc,
                                           logic [CW-1:0] rt, logic [CW-1:0] tt);
        logic [15:0] v = '0;
        v[0] = (rc >= rt); v[1] = (rc == 0); v[2] = (rc == 64);   // R1
        v[3] = (tc == 0);  v[4] = (tc == 64); v[13] = (tc >= tt); // R2
        return v;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // One clock edge; the model advances with the same inputs.
    task automatic step();
        logic [15:0] lv;
        logic [12:0] clr, setv;
        lv = live_f(rx_count, tx_count, m_rtr, m_ttr);
        clr = '0;
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_mask = m_mask | wr_data[12:0];
                3'd1: m_mask = m_mask & ~wr_data[12:0];
                3'd3: clr = wr_data[12:0];
                3'd5: m_rtr = wr_data[CW-1:0];
                3'd6: m_ttr = wr_data[CW-1:0];
                default: ;
            endcase
        end
        setv = lv[12:0];
        setv[10] = lv[13];
        setv[5] = ev_ovr; setv[6] = ev_frm; setv[7] = ev_par;
        setv[8] = ev_tmo; setv[12] = ev_tovf;
        m_sticky = (m_sticky & ~clr) | setv;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic check_all(string req);
        logic [15:0] d;
        rd(3'd2, d); chk({req, " mask"}, d, {3'b0, m_mask});
        rd(3'd3, d); chk({req, " sticky"}, d, {3'b0, m_sticky});
        rd(3'd4, d); chk({req, " live"}, d, live_f(rx_count, tx_count, m_rtr, m_ttr));
        chk({req, " irq"}, {15'b0, irq}, {15'b0, |(m_mask & m_sticky)});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3'd2, d); chk("R8 mask", d, 16'h0);
        rd(3'd3, d); chk("R8 sticky", d, 16'h0);
        rd(3'd5, d); chk("R8 rx trig", d, 16'd32);
        rd(3'd6, d); chk("R8 tx trig", d, 16'd32);
        chk("R8 irq", {15'b0, irq}, 16'h0);
        rst_n = 1;
    endtask

    task automatic t_mask();
        logic [15:0] d;
        step(); check_all("R3 after reset");
        wr(3'd0, 16'h000A); check_all("R4 set R7");
        chk("R7 irq set", {15'b0, irq}, 16'h1);
        wr(3'd2, 16'hFFFF); rd(3'd2, d); chk("R4 direct ignored", d, 16'h000A);
        wr(3'd1, 16'h0002); check_all("R4 clear");
        wr(3'd1, 16'h0008); check_all("R7 no mask");
        chk("R7 irq low", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_w1c();
        wr(3'd3, 16'h1FFF); check_all("R5 same-cycle set wins");
        rx_count = 7'd10; tx_count = 7'd5; step();
        wr(3'd3, 16'h1FFF); check_all("R5 clear");
        chk("R5 sticky empty", {3'b0, m_sticky}, 16'h0);
    endtask

    task automatic t_sweep(string req);
        logic [CW-1:0] pts[9] = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd31, 7'd32, 7'd33, 7'd63, 7'd64};
        wr(3'd0, 16'h1FFF);
        foreach (pts[i]) begin
            rx_count = pts[i]; tx_count = pts[8 - i];
            step(); check_all(req);
            wr(3'd3, 16'h1FFF); check_all({req, " R5"});
        end
    endtask

    task automatic t_events();
        logic [15:0] d;
        rx_count = 7'd5; tx_count = 7'd5;
        wr(3'd1, 16'h1FFF); wr(3'd0, 16'h1000);
        wr(3'd3, 16'h1FFF); check_all("R6 idle");
        ev_ovr = 1; step(); ev_ovr = 0; check_all("R6 overrun");
        ev_frm = 1; ev_par = 1; step(); ev_frm = 0; ev_par = 0; check_all("R6 frame parity");
        ev_tmo = 1; step(); ev_tmo = 0; check_all("R6 timeout");
        chk("R7 irq masked", {15'b0, irq}, 16'h0);
        ev_tovf = 1; step(); ev_tovf = 0; check_all("R6 tx overflow");
        chk("R7 irq tx ovf", {15'b0, irq}, 16'h1);
        rd(3'd3, d); chk("R6 reserved zero", d & 16'hEA00, 16'h0);
    endtask

    task automatic t_trig();
        logic [15:0] d;
        wr(3'd5, 16'hFF83); rd(3'd5, d); chk("R9 rx trig", d, 16'h0003);
        wr(3'd6, 16'h0000); rd(3'd6, d); chk("R9 tx trig", d, 16'h0000);
        t_sweep("R9 R1 R2 sweep");
    endtask

    initial begin
        t_reset();
        t_mask();
        t_w1c();
        t_sweep("R1 R2 R3 R7 sweep");
        t_events();
        t_trig();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule